// File: doc/BRIEF.md
# External Interrupt Edge Port

This peripheral manages eight general-purpose pins. Each pin can act as a plain input or output. Pins 1 through 7 can also raise an interrupt request to a separate interrupt controller. Priority and vectoring are handled in that controller, not here.

Software configures each pin through a small register bus. The registers cover:
- a direction bit per pin;
- an output data latch;
- an interrupt enable bit per pin;
- a two-bit trigger select per pin, which picks level, rising, falling or both edges.

Each pin input passes through a two-flop synchronizer. The synchronized value is readable by software.

In an edge mode, a qualifying transition latches a sticky flag. Software clears the flag by writing a one to it. In level mode, the flag reading and the request follow the pin directly: they are active while the pin is low.

Top module: `edge_irq_port`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` and `pin_out` are zero, and `irq_req` is zero. This means all pins are inputs, in level mode, with interrupts disabled.
- R2: The register map is as follows. Byte reads return data on `bus_rdata[7:0]`.
  - Offset 0: trigger register, written with a halfword access (`bus_half`=1).
  - Offset 2: direction register, byte write.
  - Offset 3: enable register, byte write.
  - Offset 4: output data register, byte write.
  - Offset 5: synchronized pin data, read only.
  - Offset 6: flags, written with byte writes that clear flags.
- R3: The trigger field of pin n is `trig[2n+1:2n]`, with the encoding 00 level, 01 rising, 10 falling, 11 both edges. The trigger register reads back the value written.
- R4: `pin_oe` equals the direction register, where a set bit means the pin drives. `pin_out` equals the output data register.
- R5: The pin data register shows `pin_in` after two clock edges. It still shows the old value one edge after a change.
- R6: In rising mode, a 0-to-1 transition of the synchronized pin sets the flag. A 1-to-0 transition does not.
- R7: In falling mode, only a 1-to-0 transition sets the flag. In both-edge mode, either transition sets it.
- R8: An edge flag latches whatever the enable bit is. `irq_req[n]` is asserted only when all three hold: the flag is set, enable bit n is set, and direction bit n is clear.
- R9: A byte write to offset 6 clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R10: If a qualifying edge occurs in the same cycle as a clearing write to that flag, the flag remains set.
- R11: In level mode, the flag reads 1 while the synchronized pin is low. The request is asserted while the pin is low, enabled and an input. A clearing write has no effect on it.
- R12: Pin 0 never sets a flag in any trigger mode. Flag bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_half | input | 1 | 1 for a halfword access, 0 for a byte access |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 16 | Write data; byte writes use bits [7:0] |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Output data to the pins |
| pin_oe | output | 8 | Per-pin output enable |
| irq_req | output | 7 | Interrupt requests for lines 1 to 7 |

## Verification
The bench targets the following corner cases, and what a wrong design would show for each:
- **Clearing write in the same cycle as a new rising edge.** A design that gives priority to the clear would read the flag back as zero, and the event would be lost.
- **Pin data latency.** The bench reads the pin data register one edge and two edges after a pin change. A design with a shorter synchronizer would show the new value too early.
- **Direction and enable gating.** A flag is latched while the pin is set as an output or its interrupt is disabled. A design that gates the latch instead of the request would show no flag in that case.
- **Level mode.** A design that latches the level would keep the flag after the pin goes high again. A design that honours the clearing write would drop the request while the pin is still low.
- **Pin 0.** The bench sets pin 0 to both-edge mode and toggles it. A design that lets pin 0 latch would report a flag bit 0.

// File: rtl/edge_irq_port.sv
module edge_irq_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_half,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic [7:0]  pin_in,
  output logic [7:0]  pin_out,
  output logic [7:0]  pin_oe,
  output logic [7:1]  irq_req
);
  localparam logic [2:0] A_TRIG = 3'd0, A_DIR = 3'd2, A_ENA = 3'd3,
                         A_OUT  = 3'd4, A_PIN = 3'd5, A_FLAG = 3'd6;

  logic [15:0] trig_q;
  logic [7:0]  dir_q, ena_q, out_q, flag_q;
  logic [7:0]  meta_q, sync_q, prev_q;
  logic [7:0]  hit, flag_view, flag_next, clr;
  logic        we_half, we_byte;

  assign we_half = bus_sel & bus_wr & bus_half;
  assign we_byte = bus_sel & bus_wr & ~bus_half;
  assign clr     = (we_byte && bus_addr == A_FLAG) ? bus_wdata[7:0] : 8'h00;

  always_comb begin
    logic [1:0] mode;
    hit       = '0;
    flag_view = '0;
    flag_next = '0;
    for (int i = 1; i < 8; i++) begin
      mode         = trig_q[2*i +: 2];
      hit[i]       = (mode[0] & sync_q[i] & ~prev_q[i]) | (mode[1] & ~sync_q[i] & prev_q[i]);
      flag_view[i] = (mode == 2'b00) ? ~sync_q[i] : flag_q[i];
      flag_next[i] = (mode == 2'b00) ? 1'b0 : ((flag_q[i] & ~clr[i]) | hit[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      dir_q  <= '0;
      ena_q  <= '0;
      out_q  <= '0;
      flag_q <= '0;
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
      flag_q <= flag_next;
      if (we_half && bus_addr == A_TRIG) trig_q <= bus_wdata;
      if (we_byte) begin
        case (bus_addr)
          A_DIR:   dir_q <= bus_wdata[7:0];
          A_ENA:   ena_q <= bus_wdata[7:0];
          A_OUT:   out_q <= bus_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_TRIG:  bus_rdata = trig_q;
      A_DIR:   bus_rdata = {8'h00, dir_q};
      A_ENA:   bus_rdata = {8'h00, ena_q};
      A_OUT:   bus_rdata = {8'h00, out_q};
      A_PIN:   bus_rdata = {8'h00, sync_q};
      A_FLAG:  bus_rdata = {8'h00, flag_view};
      default: bus_rdata = 16'h0000;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq_req = flag_view[7:1] & ena_q[7:1] & ~dir_q[7:1];
endmodule

module edge_irq_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input logic        half,
  input logic [2:0]  addr,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic [7:0]  pin_oe,
  input logic [7:1]  irq_req,
  input logic [15:0] trig,
  input logic [7:0]  ena,
  input logic [7:0]  dir,
  input logic [7:0]  sync,
  input logic [7:0]  prev,
  input logic [7:0]  flag
);
  assert_dir_to_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !half && addr == 3'd2) |=> (pin_oe == $past(wdata[7:0])));

  assert_pin0_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd6) |-> !rdata[0]);

  for (genvar i = 1; i < 8; i++) begin : g_line
    assert_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[2*i +: 2] == 2'b01 && sync[i] && !prev[i]) |=> flag[i]);

    assert_edge_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[2*i +: 2] == 2'b01 && sync[i] && !prev[i] && we && !half && addr == 3'd6 && wdata[i])
      |=> flag[i]);

    assert_level_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[2*i +: 2] == 2'b00 && !sync[i] && ena[i] && !dir[i]) |-> irq_req[i]);
  end
endmodule

bind edge_irq_port edge_irq_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we(bus_sel & bus_wr), .half(bus_half), .addr(bus_addr),
  .wdata(bus_wdata), .rdata(bus_rdata), .pin_oe(pin_oe), .irq_req(irq_req),
  .trig(trig_q), .ena(ena_q), .dir(dir_q), .sync(sync_q), .prev(prev_q), .flag(flag_q)
);

// File: tb/tb_edge_irq_port.sv
module tb_edge_irq_port;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0, bus_half = 0;
  logic [2:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [7:0]  pin_in = 8'hFF;
  logic [7:0]  pin_out, pin_oe;
  logic [7:1]  irq_req;

  edge_irq_port dut (.*);

  always #5 clk = ~clk;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  item_t cur;
  int    checks = 0, errors = 0;
  bit    done = 0;

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      logic [15:0] act;
      cur = sb.pop_front();
      case (cur.kind)
        0:       act = bus_rdata;
        1:       act = {8'h00, irq_req, 1'b0};
        2:       act = {8'h00, pin_oe};
        default: act = {8'h00, pin_out};
      endcase
      checks++;
      if (act !== cur.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", cur.tag, cur.kind, act, cur.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [2:0] addr, input logic [15:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = addr;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] addr, input logic [15:0] data, input logic half);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_half = half; bus_addr = addr; bus_wdata = data;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; bus_half = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk(0, 3'd0, 16'h0000, "R1 trig");
    chk(0, 3'd2, 16'h0000, "R1 dir");
    chk(0, 3'd3, 16'h0000, "R1 ena");
    chk(0, 3'd4, 16'h0000, "R1 out");
    chk(0, 3'd6, 16'h0000, "R1 flags");
    chk(1, 3'd0, 16'h0000, "R1 irq");
    chk(2, 3'd0, 16'h0000, "R1 oe");
    chk(5, 3'd0, 16'h0000, "R1 pin_out");
    chk(0, 3'd5, 16'h00FF, "R2 pin data");
    // R5 synchronizer latency
    @(posedge clk); #1 pin_in = 8'hDF;
    chk(0, 3'd5, 16'h00FF, "R5 one edge");
    chk(0, 3'd5, 16'h00DF, "R5 two edges");
    pin_in = 8'hFF; settle(3);
    // R4 direction and output data
    wr(3'd2, 16'h0081, 0);
    wr(3'd4, 16'h00A5, 0);
    chk(2, 3'd0, 16'h0081, "R4 oe");
    chk(3, 3'd0, 16'h00A5, "R4 pin_out");
    chk(0, 3'd2, 16'h0081, "R2 dir read");
    chk(0, 3'd4, 16'h00A5, "R2 out read");
    wr(3'd2, 16'h0000, 0);
    // R3 trigger fields: pin1 rise, pin2 fall, pin3 both
    wr(3'd0, 16'h00E4, 1);
    chk(0, 3'd0, 16'h00E4, "R3 trig read");
    pin_in = 8'hF1; settle(4);
    chk(0, 3'd6, 16'h000C, "R6 R7 falling edges");
    chk(1, 3'd0, 16'h0000, "R8 disabled no irq");
    wr(3'd3, 16'h000E, 0);
    chk(1, 3'd0, 16'h000C, "R8 enabled irq");
    wr(3'd6, 16'h0004, 0);
    chk(0, 3'd6, 16'h0008, "R9 clear one keep other");
    pin_in = 8'hFF; settle(4);
    chk(0, 3'd6, 16'h000A, "R6 R7 rising edges");
    wr(3'd6, 16'h000E, 0);
    chk(0, 3'd6, 16'h0000, "R9 clear all");
    // R8 output direction blocks request
    wr(3'd2, 16'h0002, 0);
    pin_in[1] = 0; settle(4);
    pin_in[1] = 1; settle(4);
    chk(0, 3'd6, 16'h0002, "R8 flag while output");
    chk(1, 3'd0, 16'h0000, "R8 output blocks irq");
    wr(3'd2, 16'h0000, 0);
    chk(1, 3'd0, 16'h0002, "R8 input irq");
    wr(3'd6, 16'h0002, 0);
    // R10 edge and clear in the same cycle
    pin_in[1] = 0; settle(4);
    chk(0, 3'd6, 16'h0000, "R6 no flag on fall");
    @(posedge clk); #1 pin_in[1] = 1;
    @(posedge clk);
    wr(3'd6, 16'h0002, 0);
    chk(0, 3'd6, 16'h0002, "R10 edge survives clear");
    wr(3'd6, 16'h0002, 0);
    // R11 level mode on pin 4
    wr(3'd3, 16'h001E, 0);
    pin_in[4] = 0; settle(3);
    chk(1, 3'd0, 16'h0010, "R11 level irq");
    chk(0, 3'd6, 16'h0010, "R11 level flag");
    wr(3'd6, 16'h0010, 0);
    chk(0, 3'd6, 16'h0010, "R11 clear no effect");
    chk(1, 3'd0, 16'h0010, "R11 irq after clear");
    pin_in[4] = 1; settle(3);
    chk(1, 3'd0, 16'h0000, "R11 level released");
    // R12 pin 0 in both-edge mode
    wr(3'd0, 16'h00E7, 1);
    wr(3'd3, 16'h001F, 0);
    pin_in[0] = 0; settle(4);
    pin_in[0] = 1; settle(4);
    chk(0, 3'd6, 16'h0000, "R12 pin0 no flag");
    chk(1, 3'd0, 16'h0000, "R12 no irq");
    settle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule